// File: doc/BRIEF.md
# Multi-Polynomial Streaming CRC Engine

This block computes a running CRC over a byte stream of any length, so that software only has to write data and read back a result. A small register write port selects one of four polynomials (a 32-bit one used by Ethernet, the 16-bit CCITT one, the 8-bit 0x1D one used on J1850 networks, and an 8-bit 0x2F one), loads a seed, sets a compare value and pushes data in 8-, 16- or 32-bit writes. Each write is broken into bytes that are folded into the accumulator one byte per clock. While bytes are pending the engine reports busy.

The finished checksum, with each mode's reflection and final inversion already applied, is always visible on `crc_value`. Generation is done by streaming the message and reading `crc_value`. Checking is done in one of two ways. Software can load the expected checksum into the compare register and watch `match`. It can also stream the message followed by its transmitted checksum and watch `verify_ok`, which is raised when the accumulator holds the polynomial's fixed residue.

Top module: `crc_engine`

## Requirements
- R1: After reset the engine is in the 32-bit mode (mode code 0) with the accumulator at its initial value. `busy` is 0, `crc_value` is 0, the compare register is 0 (so `match` is 1), and `verify_ok` is 0.
- R2: Mode code 0 uses polynomial 0x04C11DB7, init 0xFFFFFFFF, reflected input and output, and final XOR 0xFFFFFFFF. The ASCII string "123456789" gives 0xCBF43926.
- R3: Mode code 1 uses polynomial 0x1021, init 0xFFFF, no reflection and no final XOR, with the result in bits 15:0. "123456789" gives 0x29B1.
- R4: Mode code 2 uses polynomial 0x1D, init 0xFF, no reflection and final XOR 0xFF, with the result in bits 7:0. "123456789" gives 0x4B.
- R5: Mode code 3 uses polynomial 0x2F, init 0xFF, no reflection and final XOR 0xFF. "123456789" gives 0xDF.
- R6: A write to address 2 takes the mode from `wr_data[1:0]`. In the next cycle the accumulator holds that mode's init and pending bytes are dropped. `busy` is then 0, and `crc_value` is 0x0000FFFF for mode 1 and 0 for the other modes.
- R7: A write to address 1 loads `wr_data`, masked to the mode's width, into the accumulator as a raw state and drops pending bytes. `crc_value` then shows that state passed through the final XOR.
- R8: A write to address 0 with `wr_size` 0, 1, or 2/3 carries 1, 2 or 4 bytes taken from the low lanes of `wr_data`. `busy` is high for exactly that many cycles, starting in the cycle after the write. Mode 0 absorbs the least significant byte first; the other modes absorb the most significant byte first.
- R9: A data write made while `busy` is high is ignored and leaves the final CRC unchanged.
- R10: A write to address 3 sets the compare register. `match` is 1 exactly when `busy` is 0 and `crc_value` equals the compare register.
- R11: After a message followed by its own checksum, written in that mode's byte order, `verify_ok` is 1 once `busy` is 0. A corrupted checksum leaves it at 0. It is never 1 while `busy` is high.
- R12: The CRC accumulates across any number of data writes of mixed sizes. It gives the same result as the same bytes written one at a time, and it holds unchanged while no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data, 1 seed, 2 mode, 3 compare |
| wr_data | input | 32 | Write data |
| wr_size | input | 2 | Data write size: 0 byte, 1 halfword, 2 or 3 word |
| busy | output | 1 | Bytes of a data write still pending |
| crc_value | output | 32 | Final CRC of the current mode, zero extended |
| match | output | 1 | Idle and CRC equals the compare register |
| verify_ok | output | 1 | Idle and accumulator equals the mode residue |

## Verification
The properties assume that `rst_n` is held low for at least one clock edge and that inputs change only away from the rising edge. They also assume that software does not expect a data write to be accepted while `busy` is high. The idle-hold and quiet-flag properties are written to remain true even when a data write does arrive during `busy`. The stimulus drives every input on the falling edge. It deliberately issues data, seed, mode and compare writes while bytes are pending, so the cancel and ignore rules are exercised both by the properties and by the per-cycle model comparison.

// File: rtl/crc_engine.sv
module crc_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  wr_size,
  output logic        busy,
  output logic [31:0] crc_value,
  output logic        match,
  output logic        verify_ok
);

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_SEED = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam logic [1:0] A_CMP  = 2'd3;

  function automatic logic [31:0] wmask(input logic [1:0] m);
    case (m)
      2'd0:    return 32'hFFFF_FFFF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [31:0] xout(input logic [1:0] m);
    case (m)
      2'd0:    return 32'hFFFF_FFFF;
      2'd1:    return 32'h0000_0000;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [2:0] nbytes_of(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] crc_byte(input logic [1:0] m, input logic [31:0] r,
                                          input logic [7:0] b);
    logic [31:0] a;
    logic [31:0] p;
    logic [4:0]  sh;
    if (m == 2'd0) begin
      a = r ^ {24'd0, b};
      for (int i = 0; i < 8; i++)
        a = a[0] ? ((a >> 1) ^ 32'hEDB8_8320) : (a >> 1);
      return a;
    end
    case (m)
      2'd1:    begin sh = 5'd16; p = 32'h1021_0000; end
      2'd2:    begin sh = 5'd24; p = 32'h1D00_0000; end
      default: begin sh = 5'd24; p = 32'h2F00_0000; end
    endcase
    a = r << sh;
    a[31:24] = a[31:24] ^ b;
    for (int i = 0; i < 8; i++)
      a = a[31] ? ((a << 1) ^ p) : (a << 1);
    return a >> sh;
  endfunction

  function automatic logic [31:0] residue(input logic [1:0] m);
    logic [31:0] a;
    logic [31:0] x;
    int          n;
    a = 32'd0;
    x = xout(m);
    n = (m == 2'd0) ? 4 : ((m == 2'd1) ? 2 : 1);
    for (int k = 0; k < 4; k++)
      if (k < n) a = crc_byte(m, a, x[8*k +: 8]);
    return a;
  endfunction

  function automatic logic [31:0] lane_order(input logic [1:0] m, input logic [31:0] d,
                                            input logic [2:0] n);
    logic [31:0] o;
    if (m == 2'd0) return d;
    o = 32'd0;
    for (int k = 0; k < 4; k++)
      if (k < int'(n)) o[8*k +: 8] = d[8*(int'(n) - 1 - k) +: 8];
    return o;
  endfunction

  localparam logic [31:0] RES0 = residue(2'd0);
  localparam logic [31:0] RES1 = residue(2'd1);
  localparam logic [31:0] RES2 = residue(2'd2);
  localparam logic [31:0] RES3 = residue(2'd3);

  logic [1:0]  mode;
  logic [31:0] acc;
  logic [31:0] pend;
  logic [2:0]  cnt;
  logic [31:0] cmp;
  logic [31:0] res_sel;

  wire wr_data_hit = wr_en && (wr_addr == A_DATA);
  wire wr_seed_hit = wr_en && (wr_addr == A_SEED);
  wire wr_mode_hit = wr_en && (wr_addr == A_MODE);
  wire wr_cmp_hit  = wr_en && (wr_addr == A_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 2'd0;
      acc  <= 32'hFFFF_FFFF;
      pend <= 32'd0;
      cnt  <= 3'd0;
      cmp  <= 32'd0;
    end else begin
      if (wr_seed_hit) begin
        acc <= wr_data & wmask(mode);
        cnt <= 3'd0;
      end else if (wr_mode_hit) begin
        mode <= wr_data[1:0];
        acc  <= wmask(wr_data[1:0]);
        cnt  <= 3'd0;
      end else if (cnt != 3'd0) begin
        acc  <= crc_byte(mode, acc, pend[7:0]);
        pend <= pend >> 8;
        cnt  <= cnt - 3'd1;
      end else if (wr_data_hit) begin
        pend <= lane_order(mode, wr_data, nbytes_of(wr_size));
        cnt  <= nbytes_of(wr_size);
      end
      if (wr_cmp_hit) cmp <= wr_data;
    end
  end

  always_comb begin
    case (mode)
      2'd0:    res_sel = RES0;
      2'd1:    res_sel = RES1;
      2'd2:    res_sel = RES2;
      default: res_sel = RES3;
    endcase
  end

  assign busy      = (cnt != 3'd0);
  assign crc_value = (acc ^ xout(mode)) & wmask(mode);
  assign match     = !busy && (crc_value == cmp);
  assign verify_ok = !busy && (acc == res_sel);

endmodule

module crc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [1:0]  wr_size,
  input logic        busy,
  input logic [31:0] crc_value,
  input logic        match,
  input logic        verify_ok
);

  logic [3:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 4'd0;
    else if (busy) busy_run <= (busy_run == 4'd15) ? busy_run : busy_run + 4'd1;
    else           busy_run <= 4'd0;
  end

  AST_MODE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (!busy && crc_value ==
      (($past(wr_data[1:0]) == 2'd1) ? 32'h0000_FFFF : 32'h0))); // R6

  AST_SEED_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> !busy); // R7

  AST_BYTE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 2'd0 && wr_size == 2'd0) |=> busy ##1 !busy); // R8

  AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 4'd4); // R8

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!match && !verify_ok)); // R10

  AST_VERIFY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    verify_ok |-> !busy); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> $stable(crc_value)); // R12

endmodule

bind crc_engine crc_engine_chk u_chk (.*);

// File: tb/tb_crc_engine.sv
module tb_crc_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  wr_size = 2'd0;
  logic        busy;
  logic [31:0] crc_value;
  logic        match;
  logic        verify_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  always #10 clk = ~clk;

  crc_engine dut (.*);

  function automatic logic [31:0] m_mask(int m);
    return (m == 0) ? 32'hFFFF_FFFF : ((m == 1) ? 32'h0000_FFFF : 32'h0000_00FF);
  endfunction

  function automatic logic [31:0] m_final(int m, logic [31:0] s);
    if (m == 0) return ~s;
    if (m == 1) return s & 32'hFFFF;
    return (s ^ 32'hFF) & 32'hFF;
  endfunction

  function automatic logic [31:0] m_step(int m, logic [31:0] s, logic [7:0] b);
    int w;
    logic [31:0] p;
    logic fb;
    if (m == 0) begin
      for (int i = 0; i < 8; i++) begin
        fb = s[0] ^ b[i];
        s = s >> 1;
        if (fb) s = s ^ 32'hEDB8_8320;
      end
      return s;
    end
    w = (m == 1) ? 16 : 8;
    p = (m == 1) ? 32'h1021 : ((m == 2) ? 32'h1D : 32'h2F);
    for (int i = 7; i >= 0; i--) begin
      fb = s[w-1] ^ b[i];
      s = (s << 1) & m_mask(m);
      if (fb) s = s ^ p;
    end
    return s;
  endfunction

  function automatic logic [31:0] crc_of(int m, logic [7:0] q[$]);
    logic [31:0] s = m_mask(m);
    foreach (q[i]) s = m_step(m, s, q[i]);
    return m_final(m, s);
  endfunction

  // reference model
  int          m_mode;
  logic [31:0] m_st;
  logic [31:0] m_cmp;
  logic [7:0]  mq[$];
  logic [31:0] m_res[4];

  initial begin
    for (int m = 0; m < 4; m++) begin
      logic [31:0] s;
      logic [31:0] c;
      int n;
      s = m_mask(m);
      c = m_final(m, s);
      n = (m == 0) ? 4 : ((m == 1) ? 2 : 1);
      if (m == 0) for (int k = 0; k < n; k++) s = m_step(m, s, c[8*k +: 8]);
      else        for (int k = n - 1; k >= 0; k--) s = m_step(m, s, c[8*k +: 8]);
      m_res[m] = s;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_st = 32'hFFFF_FFFF; m_cmp = 0; mq.delete();
    end else begin
      if (wr_en && wr_addr == 2'd1) begin
        m_st = wr_data & m_mask(m_mode); mq.delete();
      end else if (wr_en && wr_addr == 2'd2) begin
        m_mode = int'(wr_data[1:0]); m_st = m_mask(m_mode); mq.delete();
      end else if (mq.size() != 0) begin
        m_st = m_step(m_mode, m_st, mq.pop_front());
      end else if (wr_en && wr_addr == 2'd0) begin
        int n;
        n = (wr_size == 2'd0) ? 1 : ((wr_size == 2'd1) ? 2 : 4);
        if (m_mode == 0) for (int k = 0; k < n; k++) mq.push_back(wr_data[8*k +: 8]);
        else             for (int k = n - 1; k >= 0; k--) mq.push_back(wr_data[8*k +: 8]);
      end
      if (wr_en && wr_addr == 2'd3) m_cmp = wr_data;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      logic [31:0] ec;
      logic eb;
      ec = m_final(m_mode, m_st);
      eb = (mq.size() != 0);
      chk("R8 busy per cycle", {31'd0, busy}, {31'd0, eb});
      chk("R12 crc_value per cycle", crc_value, ec);
      chk("R10 match per cycle", {31'd0, match}, {31'd0, !eb && ec == m_cmp});
      chk("R11 verify_ok per cycle", {31'd0, verify_ok}, {31'd0, !eb && m_st == m_res[m_mode]});
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size = sz;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int nb;
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;

    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 crc_value", crc_value, 32'd0);
    chk("R1 match", {31'd0, match}, 32'd1);
    chk("R1 verify_ok", {31'd0, verify_ok}, 32'd0);

    // R2 + R12 mixed sizes, LSB first
    wr(2'd0, 32'h3433_3231, 2'd2); idle();
    wr(2'd0, 32'h0000_3635, 2'd1); idle();
    wr(2'd0, 32'h0000_3837, 2'd1); idle();
    wr(2'd0, 32'h0000_0039, 2'd0); idle();
    chk("R2 check value", crc_value, 32'hCBF4_3926);
    wr(2'd3, 32'hCBF4_3926, 2'd0);
    chk("R10 match on equal", {31'd0, match}, 32'd1);
    wr(2'd3, 32'hCBF4_3927, 2'd0);
    chk("R10 no match", {31'd0, match}, 32'd0);
    wr(2'd0, 32'hCBF4_3926, 2'd2);
    chk("R11 quiet while busy", {31'd0, verify_ok}, 32'd0);
    idle();
    chk("R11 verify eth", {31'd0, verify_ok}, 32'd1);

    // R6 mode write mid-stream, R3
    wr(2'd0, 32'h1111_1111, 2'd2);
    wr(2'd2, 32'd1, 2'd0);
    chk("R6 mode cancels busy", {31'd0, busy}, 32'd0);
    chk("R6 ccitt init", crc_value, 32'h0000_FFFF);
    wr(2'd0, 32'h3132_3334, 2'd2); idle();
    wr(2'd0, 32'h3536_3738, 2'd2); idle();
    wr(2'd0, 32'h0000_0039, 2'd0); idle();
    chk("R3 check value", crc_value, 32'h0000_29B1);
    wr(2'd0, 32'h0000_29B1, 2'd1); idle();
    chk("R11 verify ccitt", {31'd0, verify_ok}, 32'd1);

    // R4 byte-wise
    wr(2'd2, 32'd2, 2'd0);
    chk("R6 j1850 init", crc_value, 32'd0);
    for (int i = 0; i < 9; i++) begin wr(2'd0, 32'h31 + i, 2'd0); idle(); end
    chk("R4 check value", crc_value, 32'h0000_004B);
    wr(2'd0, 32'h4B, 2'd0); idle();
    chk("R11 verify j1850", {31'd0, verify_ok}, 32'd1);

    // R5 and corrupted check
    wr(2'd2, 32'd3, 2'd0);
    wr(2'd0, 32'h3132_3334, 2'd3); idle();
    wr(2'd0, 32'h3536_3738, 2'd2); idle();
    wr(2'd0, 32'h39, 2'd0); idle();
    chk("R5 check value", crc_value, 32'h0000_00DF);
    wr(2'd0, 32'hDE, 2'd0); idle();
    chk("R11 corrupted", {31'd0, verify_ok}, 32'd0);

    // R8 busy lengths
    for (int s = 0; s < 3; s++) begin
      wr(2'd0, 32'hA5C3_0F96, 2'(s));
      nb = 0;
      while (busy) begin nb++; @(negedge clk); end
      chk("R8 busy cycles", nb, (s == 0) ? 1 : ((s == 1) ? 2 : 4));
    end

    // R9 write while busy ignored
    wr(2'd2, 32'd0, 2'd0);
    wr(2'd0, 32'h3433_3231, 2'd2);
    wr(2'd0, 32'hFFFF_FFFF, 2'd2);
    idle();
    q = '{8'h31, 8'h32, 8'h33, 8'h34};
    chk("R9 busy write ignored", crc_value, crc_of(0, q));

    // R7 seed
    wr(2'd1, 32'h1234_5678, 2'd0);
    chk("R7 seed eth", crc_value, 32'hEDCB_A987);
    wr(2'd2, 32'd1, 2'd0);
    wr(2'd0, 32'h0102_0304, 2'd2);
    wr(2'd1, 32'hFFFF_ABCD, 2'd0);
    chk("R7 seed cancels", {31'd0, busy}, 32'd0);
    chk("R7 seed ccitt masked", crc_value, 32'h0000_ABCD);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r < 13)      wr(2'd0, $urandom, 2'($urandom_range(0, 3)));
      else if (r < 14) wr(2'd1, $urandom, 2'd0);
      else if (r < 16) wr(2'd2, $urandom_range(0, 3), 2'd0);
      else if (r < 17) wr(2'd3, m_final(m_mode, m_st), 2'd0);
      else repeat ($urandom_range(1, 4)) @(negedge clk);
    end
    idle();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule